// File: doc/BRIEF.md
# Multi-Mode Timer and Event Counter

This block is an up-counting timer with a reload value and one 8-bit control register. It can count ticks of a divided-down system clock, count edges seen on an external event input, or measure how long a pulse on that input lasts. When the count rolls over from all ones, the counter reloads from the reload register. It then raises a one-cycle interrupt request, which the `irq_en` input can mask, and it flips a toggle output that can serve as a frequency output.

Software uses a small register bus. `reg_sel` = 0 addresses the control register and `reg_sel` = 1 addresses the counter and reload pair. `rdata` follows `reg_sel` combinationally. `rd_en` marks a read of the counter, and it freezes counting while it is high. The event input is synchronised with two flops and edge-detected in the system clock domain. The divided clock is used only as a one-cycle count enable.

Top module: `evt_timer`

## Requirements
- R1: After reset, the control register, counter, `irq` and `ovf_tgl` are 0. The control register fields are: bits 2:0 divider select, bit 3 edge select, bit 4 run, bits 7:6 mode. Bit 5 always reads 0.
- R2: Mode 00 is idle. With mode 00 the counter holds its value whatever the run bit and the event input do.
- R3: In mode 10 (timer) with run set, the counter advances once every 2^(sel+1) system clocks, where sel is bits 2:0. Code 000 gives /2 and code 111 gives /256.
- R4: In mode 01 (event) with run set, the counter advances once per rising edge of `evt_in` when bit 3 is 0, and once per falling edge when bit 3 is 1. The other edge has no effect.
- R5: In mode 11 (pulse width) with run set, counting starts on a rising edge and stops on the next falling edge when bit 3 is 1, and the reverse when bit 3 is 0. During the pulse the counter advances once every 2^(sel+1) clocks.
- R6: In mode 11 the run bit clears itself when the stop edge ends a measurement. Later pulses leave the count unchanged until software sets run again.
- R7: In modes 01 and 10 the run bit stays set until software writes it, including across overflows.
- R8: When the counter is all ones and advances, it loads the reload value. In the same clock `irq` pulses for one cycle if `irq_en` is 1. If `irq_en` is 0, `irq` stays 0.
- R9: `ovf_tgl` inverts on every overflow and at no other time.
- R10: A counter write while run is 0 loads both the reload register and the counter.
- R11: A counter write while run is 1 changes only the reload register. The counter keeps counting and takes the new value at its next overflow.
- R12: While `rd_en` is high with `reg_sel` = 1, the counter does not advance, and ticks in those cycles are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Counter read strobe, which freezes counting |
| reg_sel | input | 1 | 0: control register, 1: counter/reload |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for the selected register |
| evt_in | input | 1 | External event / pulse input (asynchronous) |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | One-cycle interrupt request on overflow |
| ovf_tgl | output | 1 | Toggles on each overflow |

## Verification
A register write takes effect at the rising edge that samples it, so the bench reads back at the following falling edge. An edge on `evt_in` shows up in the count at the third rising edge after the input changes, and the bench waits at least five cycles before it compares. The reload, `irq` and the `ovf_tgl` flip all land on the same edge, so they are checked together at the falling edge where `irq` is first seen high. Divider rates are measured as the spacing between two successive count changes, so the free-running divider phase does not matter. Pulse lengths are chosen as whole multiples of the tick period, which makes the expected count exact.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the timer/event counter.
// Assumes the control register is 8 bits with the fixed field layout below.
package tmr_pkg;
    localparam int CTRL_W   = 8;
    localparam int SEL_W    = 3;
    localparam int BIT_EDGE = 3;
    localparam int BIT_RUN  = 4;
    localparam int BIT_RSVD = 5;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_TIMER = 2'b10,
        MODE_PULSE = 2'b11
    } tmr_mode_e;
endpackage

// File: rtl/tmr_prescaler.sv
// Free-running divider that emits a one-cycle tick every 2^(sel+1) clocks.
// Assumes sel is static during use; on a change the first period may be short.
module tmr_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = 1 << SEL_W;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Free-running divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // Mask of the low sel+1 bits; a tick fires when all of them are set.
    always_comb begin
        for (int i = 0; i < DIV_W; i++) mask[i] = (i <= int'(sel));
        tick = ((div_q & mask) == mask);
    end
endmodule

// File: rtl/tmr_edge_sync.sv
// Brings an asynchronous input into the clock domain through a flop chain
// and reports single-cycle rising and falling edge strobes.
// Assumes the input is stable for at least two clocks between changes.
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Synchroniser chain, first stage samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each further stage resamples the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    // Delayed copy of the synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign rise = chain_q[STAGES-1] & ~last_q;
    assign fall = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/tmr_counter.sv
// Up counter with reload register. A direct load writes both registers;
// a preload-only write changes the reload value, used at the next wrap.
// Assumes load_now and inc are never both set.
module tmr_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         pre_wr,
    input  logic         load_now,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count,
    output logic         ovf
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] pre_q;
    logic [W-1:0] pre_next;

    assign pre_next = pre_wr ? wdata : pre_q;
    assign ovf      = inc && (count == TOP);

    // Reload register.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_next;
    end

    // Counter: direct load, wrap to reload value, or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)        count <= '0;
        else if (load_now) count <= wdata;
        else if (ovf)      count <= pre_next;
        else if (inc)      count <= count + 1'b1;
    end
endmodule

// File: rtl/evt_timer.sv
// Top of the timer/event counter: control register, mode decode,
// pulse-width state, interrupt and overflow toggle.
// Assumes CNT_W >= 8 so the control register fits on the data bus.
module evt_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             reg_sel,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    input  logic             evt_in,
    input  logic             irq_en,
    output logic             irq,
    output logic             ovf_tgl
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  count_w;
    tmr_mode_e         mode;
    logic              run, edge_sel, tick, rise, fall;
    logic              ctrl_wr, cnt_wr, rd_block;
    logic              start_edge, stop_edge, evt_edge;
    logic              measuring_q, pw_done, inc, ovf_evt;

    assign mode     = tmr_mode_e'(ctrl_q[7:6]);
    assign run      = ctrl_q[BIT_RUN];
    assign edge_sel = ctrl_q[BIT_EDGE];
    assign ctrl_wr  = wr_en && !reg_sel;
    assign cnt_wr   = wr_en && reg_sel;
    assign rd_block = rd_en && reg_sel;

    tmr_prescaler #(.SEL_W(SEL_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .sel(ctrl_q[SEL_W-1:0]), .tick(tick)
    );

    tmr_edge_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(evt_in), .rise(rise), .fall(fall)
    );

    assign evt_edge   = edge_sel ? fall : rise;
    assign start_edge = edge_sel ? rise : fall;
    assign stop_edge  = edge_sel ? fall : rise;
    assign pw_done    = run && (mode == MODE_PULSE) && measuring_q && stop_edge;

    // Control register; a software write wins over the self-clear of run.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= wdata[CTRL_W-1:0] & ~(CTRL_W'(1) << BIT_RSVD);
        else if (pw_done) ctrl_q[BIT_RUN] <= 1'b0;
    end

    // Pulse-width window: open on the start edge, close on the stop edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || mode != MODE_PULSE) measuring_q <= 1'b0;
        else if (!measuring_q && start_edge)      measuring_q <= 1'b1;
        else if (measuring_q && stop_edge)        measuring_q <= 1'b0;
    end

    // Count enable by mode, frozen during a counter read.
    always_comb begin
        unique case (mode)
            MODE_EVENT: inc = evt_edge;
            MODE_TIMER: inc = tick;
            MODE_PULSE: inc = measuring_q && tick;
            default:    inc = 1'b0;
        endcase
        inc = inc && run && !rd_block;
    end

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(inc), .pre_wr(cnt_wr),
        .load_now(cnt_wr && !run), .wdata(wdata), .count(count_w), .ovf(ovf_evt)
    );

    // Interrupt pulse and overflow toggle, updated with the reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            ovf_tgl <= 1'b0;
        end else begin
            irq     <= ovf_evt && irq_en;
            ovf_tgl <= ovf_tgl ^ ovf_evt;
        end
    end

    assign rdata = reg_sel ? count_w : CNT_W'(ctrl_q);
endmodule

// File: rtl/tmr_chk.sv
// Property checker for evt_timer, attached through bind below.
module tmr_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             reg_sel,
    input logic [CNT_W-1:0] wdata,
    input logic [CNT_W-1:0] rdata,
    input logic             irq_en,
    input logic             irq,
    input logic             ovf_tgl,
    input logic             run,
    input logic [1:0]       mode,
    input logic [CNT_W-1:0] count,
    input logic             ovf_evt
);
    // R1
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_sel) |-> !rdata[5]);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && !wr_en) |=> count == $past(count));
    // R7
    run_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode != 2'b11 && !(wr_en && !reg_sel)) |=> run);
    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ovf_evt && irq_en));
    // R9
    tgl_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_tgl != $past(ovf_tgl));
    // R9
    tgl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_evt |=> $stable(ovf_tgl));
    // R10
    stop_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel && !run) |=> count == $past(wdata));
    // R11
    run_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel && run && !ovf_evt) |=>
            (count == $past(count) || count == $past(count) + 1'b1));
    // R12
    rd_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_sel && !wr_en) |=> count == $past(count));
endmodule

bind evt_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .wdata(wdata), .rdata(rdata), .irq_en(irq_en), .irq(irq), .ovf_tgl(ovf_tgl),
    .run(ctrl_q[4]), .mode(ctrl_q[7:6]), .count(count_w), .ovf_evt(ovf_evt)
);

// File: tb/evt_timer_test.sv
module evt_timer_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, reg_sel = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       evt_in = 1'b0, irq_en = 1'b0;
    logic       irq, ovf_tgl;
    int         total = 0, bad = 0;

    evt_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
        .wdata(wdata), .rdata(rdata), .evt_in(evt_in), .irq_en(irq_en),
        .irq(irq), .ovf_tgl(ovf_tgl)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = sel; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic sel, output logic [7:0] v);
        reg_sel = sel;
        #1;
        v = rdata;
    endtask

    task automatic pulse(input int len);
        evt_in = 1'b1; wait_n(len);
        evt_in = 1'b0; wait_n(len);
    endtask

    initial begin
        #(CLK_P * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v, prev, ctl;
        int n;
        bit seen;

        wait_n(5);
        rst_n = 1'b1;
        wait_n(1);

        // R1 reset state
        peek(1'b0, v); check(v == 8'h00, "R1 ctrl reset", v, 0);
        peek(1'b1, v); check(v == 8'h00, "R1 count reset", v, 0);
        check(irq == 1'b0 && ovf_tgl == 1'b0, "R1 irq/tgl reset", {irq, ovf_tgl}, 0);

        // R1 reserved bit reads zero
        write_reg(1'b0, 8'h27);
        peek(1'b0, v); check(v == 8'h07, "R1 reserved bit", v, 8'h07);

        // R10 stopped write loads counter
        write_reg(1'b0, 8'h80);
        write_reg(1'b1, 8'h55);
        peek(1'b1, v); check(v == 8'h55, "R10 stopped load", v, 8'h55);

        // R2 idle mode holds with run set and event activity
        write_reg(1'b0, 8'h10);
        for (int i = 0; i < 6; i++) pulse(4);
        wait_n(50);
        peek(1'b1, v); check(v == 8'h55, "R2 idle hold", v, 8'h55);

        // R3 divider sweep: spacing between count changes
        for (int sel = 0; sel < 8; sel++) begin
            write_reg(1'b0, 8'h80);
            write_reg(1'b1, 8'h00);
            write_reg(1'b0, 8'h90 | 8'(sel));
            peek(1'b1, prev);
            n = 0;
            do begin @(negedge clk); n++; end while (rdata == prev && n < 1000);
            prev = rdata;
            n = 0;
            do begin @(negedge clk); n++; end while (rdata == prev && n < 1000);
            check(n == (2 << sel), $sformatf("R3 period sel=%0d", sel), n, 2 << sel);
        end

        // R8 R9 overflow reload with interrupt enabled
        write_reg(1'b0, 8'h80);
        write_reg(1'b1, 8'hFD);
        irq_en = 1'b1;
        write_reg(1'b0, 8'h90);
        reg_sel = 1'b1;
        n = 0;
        while (!irq && n < 100) begin @(negedge clk); n++; end
        check(irq == 1'b1, "R8 irq raised", irq, 1);
        check(rdata == 8'hFD, "R8 reload value", rdata, 8'hFD);
        check(ovf_tgl == 1'b1, "R9 toggle first", ovf_tgl, 1);
        @(negedge clk);
        check(irq == 1'b0, "R8 irq one cycle", irq, 0);

        // R8 masked interrupt across next overflow
        irq_en = 1'b0;
        seen = 1'b0; n = 0;
        while (ovf_tgl && n < 100) begin @(negedge clk); n++; if (irq) seen = 1'b1; end
        check(!seen, "R8 masked irq", seen, 0);
        check(ovf_tgl == 1'b0, "R9 toggle second", ovf_tgl, 0);

        // R11 running write touches only the reload value
        write_reg(1'b1, 8'h10);
        peek(1'b1, v); check(v >= 8'hFD, "R11 counter kept", v, 8'hFD);
        n = 0;
        while (!ovf_tgl && n < 100) begin @(negedge clk); n++; end
        check(rdata == 8'h10, "R11 new reload at wrap", rdata, 8'h10);
        // R7 run bit still set after overflows in timer mode
        peek(1'b0, v); check(v[4] == 1'b1, "R7 run kept", v[4], 1);

        // R12 counter read freezes counting
        @(negedge clk);
        rd_en = 1'b1; reg_sel = 1'b1;
        #1 prev = rdata;
        wait_n(20);
        check(rdata == prev, "R12 frozen during read", rdata, prev);
        rd_en = 1'b0;
        wait_n(4);
        check(rdata != prev, "R12 resumes after read", rdata, prev + 1);

        // R4 event mode, rising edges
        write_reg(1'b0, 8'h40);
        write_reg(1'b1, 8'h00);
        evt_in = 1'b0; wait_n(5);
        write_reg(1'b0, 8'h50);
        for (int i = 0; i < 5; i++) pulse(3);
        wait_n(5);
        peek(1'b1, v); check(v == 8'd5, "R4 rising count", v, 5);
        evt_in = 1'b1; wait_n(5);
        peek(1'b1, v); check(v == 8'd6, "R4 single rise", v, 6);
        evt_in = 1'b0; wait_n(5);
        peek(1'b1, v); check(v == 8'd6, "R4 fall ignored", v, 6);
        // R4 event mode, falling edges
        write_reg(1'b0, 8'h58);
        evt_in = 1'b1; wait_n(5);
        peek(1'b1, v); check(v == 8'd6, "R4 rise ignored", v, 6);
        evt_in = 1'b0; wait_n(5);
        peek(1'b1, v); check(v == 8'd7, "R4 falling count", v, 7);
        // R7 run stays set in event mode
        peek(1'b0, v); check(v[4] == 1'b1, "R7 run kept event", v[4], 1);

        // R5 R6 pulse-width sweep over polarity and divider
        for (int pol = 0; pol < 2; pol++) begin
            for (int sel = 0; sel < 3; sel++) begin
                ctl = 8'hC0 | 8'(pol << 3) | 8'(sel);
                write_reg(1'b0, ctl);
                write_reg(1'b1, 8'h00);
                evt_in = (pol == 0); wait_n(6);
                write_reg(1'b0, ctl | 8'h10);
                wait_n(2);
                evt_in = (pol == 1); wait_n(5 * (2 << sel));
                evt_in = (pol == 0); wait_n(6);
                peek(1'b1, v);
                check(v == 8'd5, $sformatf("R5 width pol=%0d sel=%0d", pol, sel), v, 5);
                peek(1'b0, v);
                check(v[4] == 1'b0, "R6 run self-clear", v[4], 0);
                evt_in = (pol == 1); wait_n(10);
                evt_in = (pol == 0); wait_n(6);
                peek(1'b1, v);
                check(v == 8'd5, "R6 no count after done", v, 5);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule